// File: doc/BRIEF.md
# ADC Regular Conversion Sequencer

This block orders the conversions of a sampling converter front end. Once started, it walks a list of sequence slots from slot 0 upward. For each slot it raises a one-cycle conversion request and then waits for the converter's done strobe. After the final slot it either falls idle (single mode) or wraps to slot 0 and runs another pass (continuous mode). A continuous run ends only when a stop command arrives.

The configuration has three parts: a sequence enable, a length field and a continuous flag. The block captures them at the moment a start command is taken, so later changes cannot disturb a pass that is already running. The length field holds N and selects slots 0 through N. When the sequence enable is low, the length field is ignored and only slot 0 is converted.

A stop command during a pass does not cut off the conversion in flight. The block waits for that conversion's done strobe, then goes idle without signalling end of sequence. The slot index output tells downstream logic which slot the current request belongs to.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Out of reset, `busy_o`, `conv_req_o` and `eos_o` are 0 and `slot_o` is 0.
- R2: A start command sampled high while idle makes `busy_o` 1 and `conv_req_o` 1 with `slot_o` = 0 in the next clock cycle. Every request lasts exactly one cycle and is only raised while busy.
- R3: With the sequence enable at 1 and length field N, a pass issues exactly N+1 requests for slots 0, 1, …, N in increasing order. N = 0 gives one request and N = 15 gives sixteen. After a done strobe for a slot that is not the last one, the request for the next slot is raised in the following cycle.
- R4: With the sequence enable at 0, a pass issues a single request for slot 0, whatever the length field holds.
- R5: In single mode (continuous flag 0), `busy_o` drops in the cycle after the done strobe for the last slot, and no further request follows.
- R6: `eos_o` is high for exactly one cycle. That cycle is the one in which the done strobe for the last slot is accepted, with no stop pending.
- R7: In continuous mode (continuous flag 1), the done strobe for the last slot is followed in the next cycle by a request for slot 0. Passes repeat, each one ending with an `eos_o` pulse.
- R8: A stop command taken while busy lets the outstanding conversion finish. The block goes idle after that conversion's done strobe, raises no `eos_o` for the unfinished pass and issues no further request.
- R9: The configuration is captured when a start command is accepted. Changes to it while busy have no effect on the running pass.
- R10: A start command while busy is ignored. The pass is neither restarted nor extended.
- R11: A done strobe while idle is ignored. `busy_o` stays 0 and no request is raised.
- R12: A stop command while idle is ignored. The next start runs a complete pass with its `eos_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_seq_en | input | 1 | Sequence enable; 0 restricts a pass to slot 0 |
| cfg_len | input | IDX_W | Last slot index N of a pass (N+1 conversions) |
| cfg_cont | input | 1 | 1 = wrap to slot 0 after the last slot |
| start_i | input | 1 | Start command, taken while idle |
| stop_i | input | 1 | Stop command, taken while busy |
| conv_done_i | input | 1 | Converter finished the requested conversion |
| slot_o | output | IDX_W | Slot index of the current request |
| conv_req_o | output | 1 | One-cycle conversion request |
| busy_o | output | 1 | A pass is in progress |
| eos_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A start taken at one rising edge shows up as a request for slot 0 in the very next cycle. A done strobe for an inner slot produces the next slot's request one cycle later. `eos_o` is combinational and appears in the same cycle as the final done strobe, and in single mode `busy_o` falls one cycle after it.

All outputs are sampled a quarter period after the falling edge. By then every register has settled from the preceding rising edge, and every input change made at the falling edge is visible. Each observed request is popped from the scoreboard queue in order, and the `eos_o` count is compared once `busy_o` is seen low.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
   localparam int unsigned SQ_IDX_W_DEF = 4;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_REQ  = 2'd1,
      SQ_WAIT = 2'd2
   } sq_state_e;
endpackage

// File: rtl/adcseq_cfg_hold.sv
module adcseq_cfg_hold #(
   parameter int unsigned IDX_W        = 4,
   parameter bit          HAS_SEQ_MODE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             seq_en_i,
   input  logic [IDX_W-1:0] len_i,
   input  logic             cont_i,
   output logic [IDX_W-1:0] last_o,
   output logic             cont_o
);
   logic [IDX_W-1:0] eff_last;
   logic [IDX_W-1:0] last_q;
   logic             cont_q;

   generate
      if (HAS_SEQ_MODE) begin : g_seq_gate
         // disabled sequence mode collapses the pass to slot 0
         assign eff_last = seq_en_i ? len_i : '0;
      end else begin : g_len_only
         assign eff_last = len_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= '0;
         cont_q <= 1'b0;
      end else if (load_i) begin
         last_q <= eff_last;
         cont_q <= cont_i;
      end
   end

   assign last_o = last_q;
   assign cont_o = cont_q;
endmodule

// File: rtl/adcseq_slot_ctr.sv
module adcseq_slot_ctr #(
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   input  logic [IDX_W-1:0] last_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             at_last_o
);
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clear_i) begin
         idx_q <= '0;
      end else if (step_i) begin
         idx_q <= idx_q + IDX_W'(1);
      end
   end

   assign idx_o     = idx_q;
   assign at_last_o = (idx_q == last_i);
endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
   import adcseq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic stop_i,
   input  logic done_i,
   input  logic at_last_i,
   input  logic cont_i,
   output logic load_o,
   output logic clear_o,
   output logic step_o,
   output logic req_o,
   output logic busy_o,
   output logic eos_o
);
   sq_state_e state_q, state_d;
   logic      stop_pend_q;
   logic      stop_now;

   assign stop_now = stop_pend_q | stop_i;

   always_comb begin
      state_d = state_q;
      load_o  = 1'b0;
      clear_o = 1'b0;
      step_o  = 1'b0;
      eos_o   = 1'b0;
      case (state_q)
         SQ_IDLE: begin
            if (start_i) begin
               load_o  = 1'b1;
               clear_o = 1'b1;
               state_d = SQ_REQ;
            end
         end
         SQ_REQ: begin
            state_d = SQ_WAIT;
         end
         SQ_WAIT: begin
            if (done_i) begin
               if (stop_now) begin
                  state_d = SQ_IDLE;
               end else if (at_last_i) begin
                  eos_o = 1'b1;
                  if (cont_i) begin
                     clear_o = 1'b1;
                     state_d = SQ_REQ;
                  end else begin
                     state_d = SQ_IDLE;
                  end
               end else begin
                  step_o  = 1'b1;
                  state_d = SQ_REQ;
               end
            end
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SQ_IDLE;
         stop_pend_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == SQ_IDLE) begin
            stop_pend_q <= 1'b0;
         end else if (stop_i) begin
            stop_pend_q <= 1'b1;
         end
      end
   end

   assign req_o  = (state_q == SQ_REQ);
   assign busy_o = (state_q != SQ_IDLE);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
   parameter int unsigned IDX_W        = adcseq_pkg::SQ_IDX_W_DEF,
   parameter bit          HAS_SEQ_MODE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_seq_en,
   input  logic [IDX_W-1:0] cfg_len,
   input  logic             cfg_cont,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             conv_done_i,
   output logic [IDX_W-1:0] slot_o,
   output logic             conv_req_o,
   output logic             busy_o,
   output logic             eos_o
);
   localparam int unsigned SLOT_CNT = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 6) begin : g_bad_width
         $error("adc_seq_ctrl: IDX_W must lie in 1..6");
      end
      if (SLOT_CNT < 2) begin : g_bad_count
         $error("adc_seq_ctrl: at least two slots required");
      end
   endgenerate

   logic             load;
   logic             clear;
   logic             step;
   logic             at_last;
   logic             cont_held;
   logic [IDX_W-1:0] last_held;

   adcseq_cfg_hold #(
      .IDX_W       (IDX_W),
      .HAS_SEQ_MODE(HAS_SEQ_MODE)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .seq_en_i(cfg_seq_en),
      .len_i   (cfg_len),
      .cont_i  (cfg_cont),
      .last_o  (last_held),
      .cont_o  (cont_held)
   );

   adcseq_slot_ctr #(
      .IDX_W(IDX_W)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (clear),
      .step_i   (step),
      .last_i   (last_held),
      .idx_o    (slot_o),
      .at_last_o(at_last)
   );

   adcseq_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .stop_i   (stop_i),
      .done_i   (conv_done_i),
      .at_last_i(at_last),
      .cont_i   (cont_held),
      .load_o   (load),
      .clear_o  (clear),
      .step_o   (step),
      .req_o    (conv_req_o),
      .busy_o   (busy_o),
      .eos_o    (eos_o)
   );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
   parameter int unsigned IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             conv_done_i,
   input logic [IDX_W-1:0] slot_o,
   input logic             conv_req_o,
   input logic             busy_o,
   input logic             eos_o
);
   // R2
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req_o |-> busy_o);
   // R2
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req_o |=> !conv_req_o);
   // R6
   eos_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eos_o |-> (conv_done_i && busy_o && !conv_req_o));
   // R6
   eos_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eos_o |=> !eos_o);
   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!conv_req_o && !eos_o));
   // R10
   slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !conv_done_i) |=> $stable(slot_o));
   // R3
   slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !conv_req_o && conv_done_i && !eos_o) |=>
         (!busy_o || slot_o == $past(slot_o) + IDX_W'(1)));
   // R7
   slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eos_o |=> (!busy_o || slot_o == '0));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .conv_done_i(conv_done_i),
   .slot_o     (slot_o),
   .conv_req_o (conv_req_o),
   .busy_o     (busy_o),
   .eos_o      (eos_o)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          seq_en = 1'b1;
   logic [IW-1:0] len = '0;
   logic          cont = 1'b0;
   logic          start = 1'b0;
   logic          stop = 1'b0;
   logic          model_done = 1'b0;
   logic          inj_done = 1'b0;
   logic          done;
   logic [IW-1:0] slot_o;
   logic          conv_req_o, busy_o, eos_o;

   assign done = model_done | inj_done;

   adc_seq_ctrl #(.IDX_W(IW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_seq_en(seq_en), .cfg_len(len),
      .cfg_cont(cont), .start_i(start), .stop_i(stop), .conv_done_i(done),
      .slot_o(slot_o), .conv_req_o(conv_req_o), .busy_o(busy_o), .eos_o(eos_o)
   );

   always #10 clk = ~clk;

   int            n_run = 0;
   int            n_fail = 0;
   int            lat = 2;
   int            eos_seen = 0;
   string         tag = "R1";
   logic [IW-1:0] exp_q[$];
   bit            mon_on = 1'b0;
   bit            prev_req = 1'b0;
   bit            prev_eos = 1'b0;

   task automatic chk(bit ok, string r, string what, int act, int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   // converter model: answers each request after lat cycles
   initial begin
      forever begin
         @(negedge clk);
         while (conv_req_o) begin
            repeat (lat) @(negedge clk);
            model_done = 1'b1;
            @(negedge clk);
            model_done = 1'b0;
         end
      end
   end

   // monitor: pops the scoreboard on every request
   initial begin
      logic [IW-1:0] e;
      forever begin
         @(negedge clk);
         #5;
         if (mon_on) begin
            if (conv_req_o) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, tag, "unexpected request for slot", int'(slot_o), -1);
               end else begin
                  e = exp_q.pop_front();
                  chk(slot_o == e, tag, "request slot", int'(slot_o), int'(e));
               end
               chk(!prev_req, "R2", "request longer than one cycle", 1, 0);
            end
            if (eos_o) begin
               eos_seen++;
               chk(!prev_eos, "R6", "eos longer than one cycle", 1, 0);
               chk(done, "R6", "eos without done strobe", 0, 1);
            end
         end
         prev_req = conv_req_o;
         prev_eos = eos_o;
      end
   end

   task automatic start_pulse(string r, bit check);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (check) begin
         #5;
         // R2: request for slot 0 one cycle after acceptance
         chk(busy_o && conv_req_o && slot_o == '0, r, "busy/req/slot0 after start",
             {busy_o, conv_req_o}, 3);
      end
   endtask

   task automatic run(string r, bit se, int ln, bit ct, int passes, int tail);
      int last;
      tag = r;
      eos_seen = 0;
      @(negedge clk);
      seq_en = se;
      len = IW'(ln);
      cont = ct;
      last = se ? ln : 0;
      for (int p = 0; p < passes; p++)
         for (int s = 0; s <= last; s++) exp_q.push_back(IW'(s));
      for (int t = 0; t < tail; t++) exp_q.push_back('0);
      start_pulse("R2", 1'b1);
   endtask

   task automatic wait_idle(string r, int exp_eos);
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         #5;
         if (!busy_o) break;
      end
      chk(!busy_o, r, "still busy", int'(busy_o), 0);
      chk(exp_q.size() == 0, r, "requests still outstanding", exp_q.size(), 0);
      chk(eos_seen == exp_eos, r, "eos pulses", eos_seen, exp_eos);
      repeat (4) @(negedge clk);
   endtask

   task automatic stop_pulse();
      @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #5;
      // R1: reset state
      chk(!busy_o, "R1", "busy in reset", int'(busy_o), 0);
      chk(!conv_req_o && !eos_o, "R1", "req/eos in reset", {conv_req_o, eos_o}, 0);
      chk(slot_o == '0, "R1", "slot in reset", int'(slot_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      #5;
      chk(!busy_o && slot_o == '0, "R1", "state after reset", int'(busy_o), 0);

      // R3 R5 R6: four-slot single pass
      lat = 2;
      run("R3", 1'b1, 3, 1'b0, 1, 0);
      wait_idle("R5", 1);
      // R3: longest pass, minimal latency
      lat = 1;
      run("R3", 1'b1, 15, 1'b0, 1, 0);
      wait_idle("R3", 1);
      // R3: length zero
      lat = 3;
      run("R3", 1'b1, 0, 1'b0, 1, 0);
      wait_idle("R6", 1);
      // R4: sequence disabled ignores length 9
      lat = 2;
      run("R4", 1'b0, 9, 1'b0, 1, 0);
      wait_idle("R4", 1);

      // R7: continuous, two full passes then stop during slot 0 of the third
      run("R7", 1'b1, 2, 1'b1, 2, 1);
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         #5;
         if (eos_seen >= 2) break;
      end
      stop_pulse();
      wait_idle("R8", 2);

      // R8: stop mid single pass after slot 1 request
      tag = "R8";
      eos_seen = 0;
      @(negedge clk);
      seq_en = 1'b1;
      len = IW'(5);
      cont = 1'b0;
      exp_q.push_back(IW'(0));
      exp_q.push_back(IW'(1));
      start_pulse("R8", 1'b0);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         #5;
         if (conv_req_o && slot_o == IW'(1)) break;
      end
      stop_pulse();
      wait_idle("R8", 0);

      // R9: configuration changed while busy has no effect
      run("R9", 1'b1, 3, 1'b0, 1, 0);
      @(negedge clk);
      seq_en = 1'b0;
      len = IW'(7);
      cont = 1'b1;
      wait_idle("R9", 1);

      // R10: second start while busy ignored
      run("R10", 1'b1, 2, 1'b0, 1, 0);
      repeat (3) @(negedge clk);
      start_pulse("R10", 1'b0);
      wait_idle("R10", 1);

      // R11: done strobe while idle
      tag = "R11";
      @(negedge clk);
      inj_done = 1'b1;
      @(negedge clk);
      inj_done = 1'b0;
      #5;
      chk(!busy_o && !conv_req_o, "R11", "activity after idle done", {busy_o, conv_req_o}, 0);

      // R12: stop while idle, then a full pass
      tag = "R12";
      stop_pulse();
      #5;
      chk(!busy_o, "R12", "busy after idle stop", int'(busy_o), 0);
      run("R12", 1'b1, 1, 1'b0, 1, 0);
      wait_idle("R12", 1);

      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end
endmodule